// File: doc/BRIEF.md
# Cascaded Converter Read Controller

This block is the host-side master for a row of serially cascaded analog-to-digital converters that share one conversion-start line and one serial clock. A start request latches the configuration (start-pulse width, serial clock half-period and clock idle level). The block then drives a single conversion-start pulse to every device, so all of them sample together. It waits for the shared busy line to rise and then fall again. Only after that does it pull chip select and read enable low and run a burst of serial clock pulses.

The serial clock sits at its idle level at all times outside the read burst, so no edges reach the converters while they are converting. One burst holds fourteen pulses per device. Each bit is sampled on the edge that leaves the idle level, and the devices shift the next bit out on the edge that returns to idle. The stream arrives device after device, nearest device first, most significant bit first. It is split into one fourteen-bit word per device. A one-cycle done pulse marks the end of the burst.

The requested half-period is raised to a floor. With a single device the floor keeps the clock within the fast limit. With several devices a larger floor leaves room for the output delay plus input setup that the cascade needs. A second start request made while a cycle is in progress is dropped.

Top module: `chain_read_host`

## Requirements
- R1: A start request accepted in idle drives `conv_start_o` high for exactly max(`conv_pw_i`,1) clock cycles, starting the cycle after the request, and at no other time.
- R2: `cs_n_o` and `rd_n_o` stay high until the busy line has been seen high and then low after the start pulse. Both go low together in the cycle after busy is sampled low, and both stay low for the whole burst.
- R3: The serial clock idle level equals `idle_high_i` latched at the accepted start (1 = idles high). After reset the latched level is 0. Outside the burst the clock never leaves this level.
- R4: The serial clock half-period in clock cycles is H = max(`half_div_i`, MIN). MIN is SOLO_MIN_HALF (3) when N_DEV = 1 and CHAIN_MIN_HALF (5) when N_DEV > 1. The burst starts with H idle cycles, then alternates active and idle for H cycles each.
- R5: Exactly N_DEV×14 clock pulses are issued per burst. Bit b is sampled from `sdo_i` at the edge where the clock leaves idle, at H·(2b+1) cycles after chip select falls. Each word is built MSB first.
- R6: Bits 14k to 14k+13 of the stream form word k, placed at `words_o[14k +: 14]`. Word 0 is the first device read, the one nearest the host.
- R7: `done_o` is high for exactly one cycle, 2·H·N_DEV·14 cycles after chip select falls. That is the same cycle in which `cs_n_o` returns high and `words_o` shows the new words.
- R8: `active_o` is high from the cycle after an accepted start until the cycle with `done_o`. A start request made while `active_o` is high, or in the cycle the burst ends, is ignored.
- R9: After reset: `conv_start_o`=0, `cs_n_o`=`rd_n_o`=1, `sclk_o`=0, `done_o`=0, `active_o`=0 and `words_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one convert-and-read cycle |
| idle_high_i | input | 1 | Serial clock idle level, latched at start |
| half_div_i | input | DIV_W | Requested serial clock half-period in clock cycles |
| conv_pw_i | input | PW_W | Conversion-start pulse width in clock cycles (0 acts as 1) |
| busy_i | input | 1 | Shared busy line from the converters |
| sdo_i | input | 1 | Serial data from the device nearest the host |
| conv_start_o | output | 1 | Common conversion-start pulse |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read enable, active low |
| sclk_o | output | 1 | Discontinuous serial clock |
| words_o | output | N_DEV*14 | Captured words, word k at bits 14k+13..14k |
| done_o | output | 1 | One-cycle end-of-read strobe |
| active_o | output | 1 | A cycle is in progress; starts are blocked |

## Verification
Every output of this block comes from a register. The start pulse begins one cycle after the request. Chip select falls one cycle after busy is sampled low. The clock level changes one cycle after each multiple of H within the burst, and the done strobe and new words arrive 2·H·N_DEV·14 cycles after chip select falls. The bench keeps a behavioural timeline that advances on the same rising edge as the design and applies these offsets. It compares every output on the falling edge that follows. The converter model updates its data line only on return-to-idle edges, so a capture on the wrong edge shows up in the words.

// File: rtl/crh_pkg.sv
package crh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_READ
    } rd_state_e;
endpackage

// File: rtl/crh_sclk_gen.sv
module crh_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic             pol_i,
    output logic             sclk_o,
    output logic             lead_o,
    output logic             trail_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } gen_t;

    gen_t g_d, g_q;
    logic wrap;

    always_comb begin
        g_d   = g_q;
        wrap  = run_i && (g_q.cnt == half_i - DIV_W'(1));
        if (!run_i) begin
            g_d.cnt = '0;
            g_d.ph  = 1'b0;
        end else if (wrap) begin
            g_d.cnt = '0;
            g_d.ph  = ~g_q.ph;
        end else begin
            g_d.cnt = g_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign lead_o  = wrap && !g_q.ph;
    assign trail_o = wrap &&  g_q.ph;
    assign sclk_o  = pol_i ^ g_q.ph;

    // R4: a running generator never sees a zero half-period
    a_r4_half_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (half_i != '0));
    // R3: the clock leaves idle only while running
    a_r3_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !g_q.ph);
endmodule

// File: rtl/crh_capture.sv
module crh_capture #(
    parameter int N_DEV  = 2,
    parameter int WORD_W = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_i,
    input  logic                    sdi_i,
    input  logic                    load_i,
    output logic [N_DEV*WORD_W-1:0] words_o
);
    localparam int TOT = N_DEV * WORD_W;

    typedef struct packed {
        logic [TOT-1:0] sh;
        logic [TOT-1:0] words;
    } cap_t;

    cap_t c_d, c_q;
    logic [TOT-1:0] unpacked;

    // stream bit 0 lands at sh[TOT-1]; word k takes the k-th group of the stream
    for (genvar k = 0; k < N_DEV; k++) begin : g_word
        assign unpacked[k*WORD_W +: WORD_W] = c_q.sh[TOT-1-k*WORD_W -: WORD_W];
    end

    always_comb begin
        c_d = c_q;
        if (shift_i) c_d.sh = {c_q.sh[TOT-2:0], sdi_i};
        if (load_i)  c_d.words = unpacked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign words_o = c_q.words;

    // R5: the last shift is complete before the words are loaded
    a_r5_no_shift_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !shift_i);
endmodule

// File: rtl/chain_read_host.sv
module chain_read_host #(
    parameter int N_DEV          = 2,
    parameter int WORD_W         = 14,
    parameter int DIV_W          = 8,
    parameter int PW_W           = 8,
    parameter int SOLO_MIN_HALF  = 3,
    parameter int CHAIN_MIN_HALF = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    idle_high_i,
    input  logic [DIV_W-1:0]        half_div_i,
    input  logic [PW_W-1:0]         conv_pw_i,
    input  logic                    busy_i,
    input  logic                    sdo_i,
    output logic                    conv_start_o,
    output logic                    cs_n_o,
    output logic                    rd_n_o,
    output logic                    sclk_o,
    output logic [N_DEV*WORD_W-1:0] words_o,
    output logic                    done_o,
    output logic                    active_o
);
    import crh_pkg::*;

    localparam int TOT      = N_DEV * WORD_W;
    localparam int BIT_W    = $clog2(TOT + 1);
    localparam int MIN_HALF = (N_DEV > 1) ? CHAIN_MIN_HALF : SOLO_MIN_HALF;
    localparam logic [DIV_W-1:0] MIN_HALF_V = DIV_W'(MIN_HALF);

    typedef struct packed {
        rd_state_e        st;
        logic [PW_W-1:0]  pcnt;
        logic [BIT_W-1:0] nbit;
        logic [PW_W-1:0]  pw;
        logic [DIV_W-1:0] div;
        logic             pol;
        logic             done;
    } ctl_t;

    ctl_t s_d, s_q;
    logic [DIV_W-1:0] half_eff;
    logic [PW_W-1:0]  pw_eff;
    logic             lead, trail, fin, reading;

    assign half_eff = (s_q.div < MIN_HALF_V) ? MIN_HALF_V : s_q.div;
    assign pw_eff   = (s_q.pw == '0) ? PW_W'(1) : s_q.pw;
    assign reading  = (s_q.st == ST_READ);
    assign fin      = reading && trail && (s_q.nbit == BIT_W'(TOT - 1));

    crh_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (reading),
        .half_i  (half_eff),
        .pol_i   (s_q.pol),
        .sclk_o  (sclk_o),
        .lead_o  (lead),
        .trail_o (trail)
    );

    crh_capture #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (reading && lead),
        .sdi_i   (sdo_i),
        .load_i  (fin),
        .words_o (words_o)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.st   = ST_PULSE;
                    s_d.pcnt = '0;
                    s_d.pw   = conv_pw_i;
                    s_d.div  = half_div_i;
                    s_d.pol  = idle_high_i;
                end
            end
            ST_PULSE: begin
                if (s_q.pcnt == pw_eff - PW_W'(1)) s_d.st = ST_WAIT_HI;
                else                                s_d.pcnt = s_q.pcnt + PW_W'(1);
            end
            ST_WAIT_HI: begin
                if (busy_i) s_d.st = ST_WAIT_LO;
            end
            ST_WAIT_LO: begin
                if (!busy_i) begin
                    s_d.st   = ST_READ;
                    s_d.nbit = '0;
                end
            end
            ST_READ: begin
                if (trail) s_d.nbit = s_q.nbit + BIT_W'(1);
                if (fin) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign conv_start_o = (s_q.st == ST_PULSE);
    assign cs_n_o       = !reading;
    assign rd_n_o       = !reading;
    assign done_o       = s_q.done;
    assign active_o     = (s_q.st != ST_IDLE);

    // R1: no read activity while the start pulse is high
    a_r1_pulse_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start_o |-> (cs_n_o && sclk_o == s_q.pol));
    // R2: chip select falls only after busy was sampled low
    a_r2_read_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !$past(busy_i));
    // R3: clock at idle level whenever chip select is high
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> (sclk_o == s_q.pol));
    // R7: done lasts one cycle and coincides with chip select release
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r7_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($rose(cs_n_o) && !active_o));
    // R8: a start during a read does not launch a new pulse
    a_r8_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (reading && start_i) |=> !conv_start_o);
endmodule

// File: tb/tb_chain_read_host.sv
module tb_chain_read_host;
    localparam int N_DEV = 2;
    localparam int WW    = 14;
    localparam int TOT   = N_DEV * WW;
    localparam int MINH  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, idle_high_i = 1'b0, busy_i = 1'b0, sdo_i = 1'b0;
    logic [7:0] half_div_i = 8'd0, conv_pw_i = 8'd0;
    logic conv_start_o, cs_n_o, rd_n_o, sclk_o, done_o, active_o;
    logic [TOT-1:0] words_o;

    always #2.5 clk = ~clk;

    chain_read_host dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .idle_high_i(idle_high_i),
        .half_div_i(half_div_i), .conv_pw_i(conv_pw_i), .busy_i(busy_i), .sdo_i(sdo_i),
        .conv_start_o(conv_start_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .sclk_o(sclk_o),
        .words_o(words_o), .done_o(done_o), .active_o(active_o)
    );

    int checks = 0, errors = 0;
    logic [WW-1:0] devw [N_DEV];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural timeline: 0 idle, 1 pulse, 2 wait busy high, 3 wait busy low, 4 read
    int m_ph = 0, m_t = 0, m_p = 1, m_h = MINH;
    bit m_pol = 1'b0, m_done = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            m_done = 1'b0;
            case (m_ph)
                0: if (start_i) begin
                       m_ph = 1; m_t = 0;
                       m_p = (conv_pw_i == 0) ? 1 : int'(conv_pw_i);
                       m_h = (int'(half_div_i) < MINH) ? MINH : int'(half_div_i);
                       m_pol = idle_high_i;
                   end
                1: begin m_t++; if (m_t == m_p) m_ph = 2; end
                2: if (busy_i) m_ph = 3;
                3: if (!busy_i) begin m_ph = 4; m_t = 0; end
                default: begin
                    m_t++;
                    if (m_t == 2 * m_h * TOT) begin m_ph = 0; m_done = 1'b1; end
                end
            endcase
        end
    end

    // per-cycle comparison, then converter model drives busy and data
    int btimer = 0, bidx = 0;
    bit prev_cnv = 1'b0, prev_sclk = 1'b0, cmp_on = 1'b0;
    always @(negedge clk) begin
        bit exp_sclk;
        if (cmp_on) begin
            exp_sclk = m_pol ^ ((m_ph == 4) && (((m_t / m_h) % 2) == 1));
            chk(conv_start_o == (m_ph == 1), "R1", "conv_start", conv_start_o, m_ph == 1);
            chk(cs_n_o == (m_ph != 4), "R2", "cs_n", cs_n_o, m_ph != 4);
            chk(rd_n_o == (m_ph != 4), "R2", "rd_n", rd_n_o, m_ph != 4);
            chk(sclk_o == exp_sclk, "R4", "sclk", sclk_o, exp_sclk);
            chk(done_o == m_done, "R7", "done", done_o, m_done);
            chk(active_o == (m_ph != 0), "R8", "active", active_o, m_ph != 0);
        end
        if (prev_cnv && !conv_start_o) btimer = 23;
        if (btimer > 0) btimer--;
        busy_i = (btimer > 0 && btimer <= 20);
        prev_cnv = conv_start_o;
        if (cs_n_o) bidx = 0;
        else if (prev_sclk != m_pol && sclk_o == m_pol) bidx++;
        prev_sclk = sclk_o;
        sdo_i = (bidx < TOT) ? devw[bidx / WW][WW - 1 - (bidx % WW)] : 1'b0;
    end

    task automatic run(input int pw, input int dv, input bit pol, input bit inject);
        int n;
        bit got;
        @(negedge clk);
        conv_pw_i = 8'(pw); half_div_i = 8'(dv); idle_high_i = pol; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (cs_n_o && n < 2000) begin @(negedge clk); n++; end
        chk(sclk_o == pol, "R3", "idle level at chip select fall", sclk_o, pol);
        if (inject) begin
            repeat (40) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        got = 1'b0;
        for (int i = 0; i < 5000 && !got; i++) begin
            if (done_o) got = 1'b1;
            else @(negedge clk);
        end
        chk(got, "R7", "done seen", got, 1);
        for (int k = 0; k < N_DEV; k++) begin
            chk(words_o[k*WW +: WW] == devw[k], (k == 0) ? "R6" : "R5",
                $sformatf("word %0d", k), words_o[k*WW +: WW], devw[k]);
        end
        repeat (3) @(negedge clk);
        chk(!conv_start_o && sclk_o == pol, "R8", "no restart after injected start",
            conv_start_o, 0);
    endtask

    initial begin
        #(150000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        devw[0] = 14'h2ABC; devw[1] = 14'h1357;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(conv_start_o == 0, "R9", "conv_start", conv_start_o, 0);
        chk(cs_n_o && rd_n_o, "R9", "cs_n/rd_n", {cs_n_o, rd_n_o}, 3);
        chk(sclk_o == 0, "R9", "sclk", sclk_o, 0);
        chk(done_o == 0 && active_o == 0, "R9", "done/active", {done_o, active_o}, 0);
        chk(words_o == '0, "R9", "words", words_o, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        run(3, 2, 1'b0, 1'b0);          // divider below chain floor
        devw[0] = 14'h3FFF; devw[1] = 14'h0000;
        run(0, 7, 1'b1, 1'b0);          // zero width pulse, idle high
        devw[0] = 14'h0001; devw[1] = 14'h2000;
        run(2, 6, 1'b0, 1'b1);          // start injected mid-read
        devw[0] = 14'h1555; devw[1] = 14'h2AAA;
        run(5, 5, 1'b1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule